// File: doc/BRIEF.md
# DMA Channel Register File

This block holds the per-channel control and status registers of a small multi-channel DMA controller. Each channel has a control word, a source address, a destination address and a transfer count. One shared word holds an interrupt-pending bit for each channel. Two masters write the bank: a simple CPU register bus, and a DMA write port that carries the number of the channel currently doing the transfer. The CPU bus also reads the bank back.

The bank decides, per channel, which writes it accepts. The decision depends on whether that channel's transfer is enabled.
- The transfer count is frozen while its channel is enabled.
- The request flag and the interrupt-pending bits only react to zeros.
- A CPU attempt to change the mode or the addresses of a running channel is dropped and recorded in a sticky violation flag.
- A DMA write that targets the registers of its own active channel is refused, and an error pulse is raised.

The transfer engine is outside this block. It talks to the bank through three things: per-channel request-set strobes, per-channel count-decrement strobes, and the active-channel number that comes with each DMA write.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset every register is 0. All channels are disabled, `irq_pending`, `viol_flag` and `dma_self_err` are 0, and every register reads back 0.
- R2: Register map and timing.
  - Word address bits [1:0] select the register: 0 = control, 1 = source, 2 = destination, 3 = count.
  - The upper address bits select the channel. Channel field value NUM_CH with select 0 is the interrupt-pending word, with bit i belonging to channel i.
  - Control word layout: bit 0 = enable, bit 1 = request, bits [2+MODE_W-1:2] = mode.
  - A read returns data with `cpu_rvalid` one cycle after `cpu_rd_en`.
  - A write takes effect at the second rising edge after it is presented.
- R3: While a channel is enabled, a write to its count is ignored and the stored count is kept.
- R4: Writing 0 to the request bit clears the request flag. Writing 1 leaves it unchanged. A `req_set` strobe sets it, and the strobe wins over a clear applied at the same edge.
- R5: In the interrupt-pending word, a bit written with 0 is cleared and a bit written with 1 keeps its value.
- R6: A `cnt_dec` strobe decrements the count of an enabled channel whose count is nonzero. It has no effect on a disabled channel or on a zero count. The step from 1 to 0 sets that channel's pending bit, and this set wins over a clear applied at the same edge.
- R7: The enable and request bits accept writes at any time. Mode, source and destination accept CPU writes only while their channel is disabled.
- R8: A CPU write to the source or destination of an enabled channel is dropped and sets that channel's sticky `viol_flag` bit. A control write that tries to change the mode of an enabled channel does the same. Writing the unchanged mode does not set the flag.
- R9: A DMA write issued by the active channel to the source or destination of another channel is accepted, even while that channel is enabled, and does not set `viol_flag`.
- R10: A DMA write whose target channel equals `dma_active_ch` changes nothing. It pulses `dma_self_err` high for one cycle, one cycle after the write is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_wr_en | input | 1 | CPU write strobe |
| cpu_rd_en | input | 1 | CPU read strobe |
| cpu_addr | input | RA_W | CPU word address (channel, register select) |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rdata | output | 32 | Read data |
| cpu_rvalid | output | 1 | Read data valid |
| dma_wr_en | input | 1 | DMA write strobe |
| dma_active_ch | input | CH_W | Channel issuing the DMA write |
| dma_addr | input | RA_W | DMA word address |
| dma_wdata | input | 32 | DMA write data |
| req_set | input | NUM_CH | Per-channel request set strobes |
| cnt_dec | input | NUM_CH | Per-channel count decrement strobes |
| chan_en | output | NUM_CH | Enable bit of each channel |
| irq_pending | output | NUM_CH | Interrupt-pending bits |
| viol_flag | output | NUM_CH | Sticky CPU write-violation flags |
| dma_self_err | output | 1 | Refused self-targeted DMA write |

## Verification
A count that was wrongly rewritten or wrongly decremented shows in a count read-back on the next read. It also shows at `irq_pending` at the edge where the count should, or should not, reach zero. A lost or wrongly applied lock on mode or address shows as a changed read-back value and as a `viol_flag` bit that does not match the expected value in the cycle after the write lands. A request or pending bit that reacts to ones, or a set that loses to a clear, shows directly at `irq_pending` or in the control read-back. A self-targeted DMA write that is not blocked shows as a changed address read-back, and its error pulse is visible exactly one cycle after the write.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
  localparam int DW = 32;
  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_REQ_BIT  = 1;
  localparam int CTRL_MODE_LSB = 2;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_SRC  = 2'd1,
    SEL_DST  = 2'd2,
    SEL_CNT  = 2'd3
  } reg_sel_e;

  // zero-write clears, one-write keeps, hardware set dominates
  function automatic logic sticky_bit_next(input logic cur, input logic wr_hit,
                                           input logic wr_bit, input logic hw_set);
    logic nxt;
    nxt = (wr_hit && !wr_bit) ? 1'b0 : cur;
    return nxt | hw_set;
  endfunction

  // the last decrement before reaching zero
  function automatic logic final_beat(input logic [DW-1:0] cnt);
    return cnt == DW'(1);
  endfunction
endpackage

// File: rtl/dma_wr_stage.sv
module dma_wr_stage
  import dma_regs_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int RA_W       = 5,
  parameter int CH_W       = 2,
  parameter bit CHECK_SELF = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [RA_W-1:0]   addr,
  input  logic [DW-1:0]     wdata,
  input  logic [CH_W-1:0]   active_ch,
  output logic [NUM_CH-1:0] hit_oh,
  output reg_sel_e          sel,
  output logic              irq_hit,
  output logic [DW-1:0]     data,
  output logic [NUM_CH-1:0] self_oh
);
  logic [RA_W-3:0]   ch_field;
  logic [NUM_CH-1:0] hit_d, self_d;
  logic              irq_d;

  assign ch_field = addr[RA_W-1:2];
  assign irq_d    = !CHECK_SELF && wr_en && (int'(ch_field) == NUM_CH) && (addr[1:0] == 2'd0);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    logic tgt;
    assign tgt       = wr_en && (int'(ch_field) == i);
    assign self_d[i] = CHECK_SELF && tgt && (int'(active_ch) == i);
    assign hit_d[i]  = tgt && !self_d[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_oh  <= '0;
      self_oh <= '0;
      irq_hit <= 1'b0;
      sel     <= SEL_CTRL;
      data    <= '0;
    end else begin
      hit_oh  <= hit_d;
      self_oh <= self_d;
      irq_hit <= irq_d;
      sel     <= reg_sel_e'(addr[1:0]);
      data    <= wdata;
    end
  end
endmodule

// File: rtl/dma_chan_slice.sv
module dma_chan_slice
  import dma_regs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int MODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_hit,
  input  reg_sel_e          cpu_sel,
  input  logic [DW-1:0]     cpu_data,
  input  logic              dma_hit,
  input  reg_sel_e          dma_sel,
  input  logic [DW-1:0]     dma_data,
  input  logic              req_set,
  input  logic              cnt_dec,
  output logic              en_q,
  output logic              req_q,
  output logic [MODE_W-1:0] mode_q,
  output logic [ADDR_W-1:0] src_q,
  output logic [ADDR_W-1:0] dst_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              viol_q,
  output logic              zero_evt
);
  logic cpu_ctrl, cpu_src, cpu_dst, cpu_cnt;
  logic dma_ctrl, dma_src, dma_dst, dma_cnt;
  logic mode_clash, addr_clash, dec_go, req_n;

  always_comb begin
    cpu_ctrl   = cpu_hit && cpu_sel == SEL_CTRL;
    cpu_src    = cpu_hit && cpu_sel == SEL_SRC;
    cpu_dst    = cpu_hit && cpu_sel == SEL_DST;
    cpu_cnt    = cpu_hit && cpu_sel == SEL_CNT;
    dma_ctrl   = dma_hit && dma_sel == SEL_CTRL;
    dma_src    = dma_hit && dma_sel == SEL_SRC;
    dma_dst    = dma_hit && dma_sel == SEL_DST;
    dma_cnt    = dma_hit && dma_sel == SEL_CNT;
    mode_clash = cpu_ctrl && en_q && (cpu_data[CTRL_MODE_LSB +: MODE_W] != mode_q);
    addr_clash = en_q && (cpu_src || cpu_dst);
    dec_go     = en_q && cnt_dec && (cnt_q != '0);
    zero_evt   = dec_go && final_beat(DW'(cnt_q));
    req_n      = sticky_bit_next(req_q, cpu_ctrl, cpu_data[CTRL_REQ_BIT], 1'b0);
    req_n      = sticky_bit_next(req_n, dma_ctrl, dma_data[CTRL_REQ_BIT], req_set);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      req_q  <= 1'b0;
      mode_q <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      viol_q <= 1'b0;
    end else begin
      req_q  <= req_n;
      viol_q <= viol_q | mode_clash | addr_clash;
      if (cpu_ctrl) en_q <= cpu_data[CTRL_EN_BIT];
      if (dma_ctrl) en_q <= dma_data[CTRL_EN_BIT];
      if (!en_q) begin
        if (cpu_ctrl) mode_q <= cpu_data[CTRL_MODE_LSB +: MODE_W];
        if (dma_ctrl) mode_q <= dma_data[CTRL_MODE_LSB +: MODE_W];
        if (cpu_src)  src_q  <= cpu_data[ADDR_W-1:0];
        if (cpu_dst)  dst_q  <= cpu_data[ADDR_W-1:0];
        if (cpu_cnt)  cnt_q  <= cpu_data[CNT_W-1:0];
        if (dma_cnt)  cnt_q  <= dma_data[CNT_W-1:0];
      end else if (dec_go) begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
      if (dma_src) src_q <= dma_data[ADDR_W-1:0];
      if (dma_dst) dst_q <= dma_data[ADDR_W-1:0];
    end
  end
endmodule

// File: rtl/dma_irq_bank.sv
module dma_irq_bank
  import dma_regs_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_hit,
  input  logic [DW-1:0]     clr_data,
  input  logic [NUM_CH-1:0] hw_set,
  output logic [NUM_CH-1:0] pend_q
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[i] <= 1'b0;
      else        pend_q[i] <= sticky_bit_next(pend_q[i], clr_hit, clr_data[i], hw_set[i]);
    end
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regs_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int MODE_W = 4,
  localparam int RA_W  = $clog2(NUM_CH + 1) + 2,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr_en,
  input  logic              cpu_rd_en,
  input  logic [RA_W-1:0]   cpu_addr,
  input  logic [31:0]       cpu_wdata,
  output logic [31:0]       cpu_rdata,
  output logic              cpu_rvalid,
  input  logic              dma_wr_en,
  input  logic [CH_W-1:0]   dma_active_ch,
  input  logic [RA_W-1:0]   dma_addr,
  input  logic [31:0]       dma_wdata,
  input  logic [NUM_CH-1:0] req_set,
  input  logic [NUM_CH-1:0] cnt_dec,
  output logic [NUM_CH-1:0] chan_en,
  output logic [NUM_CH-1:0] irq_pending,
  output logic [NUM_CH-1:0] viol_flag,
  output logic              dma_self_err
);
  logic [NUM_CH-1:0]              cpu_hit_oh, dma_hit_oh, self_oh, cpu_self_unused, zero_evt, ch_req;
  reg_sel_e                       cpu_sel, dma_sel;
  logic                           cpu_irq_hit, dma_irq_unused;
  logic [DW-1:0]                  cpu_data, dma_data, rd_word;
  logic [NUM_CH-1:0][MODE_W-1:0]  ch_mode;
  logic [NUM_CH-1:0][ADDR_W-1:0]  ch_src, ch_dst;
  logic [NUM_CH-1:0][CNT_W-1:0]   ch_cnt;
  logic [RA_W-3:0]                rd_ch;

  dma_wr_stage #(.NUM_CH(NUM_CH), .RA_W(RA_W), .CH_W(CH_W), .CHECK_SELF(1'b0)) cpu_stage_i (
    .clk(clk), .rst_n(rst_n), .wr_en(cpu_wr_en), .addr(cpu_addr), .wdata(cpu_wdata),
    .active_ch('0), .hit_oh(cpu_hit_oh), .sel(cpu_sel), .irq_hit(cpu_irq_hit),
    .data(cpu_data), .self_oh(cpu_self_unused));

  dma_wr_stage #(.NUM_CH(NUM_CH), .RA_W(RA_W), .CH_W(CH_W), .CHECK_SELF(1'b1)) dma_stage_i (
    .clk(clk), .rst_n(rst_n), .wr_en(dma_wr_en), .addr(dma_addr), .wdata(dma_wdata),
    .active_ch(dma_active_ch), .hit_oh(dma_hit_oh), .sel(dma_sel), .irq_hit(dma_irq_unused),
    .data(dma_data), .self_oh(self_oh));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    dma_chan_slice #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .MODE_W(MODE_W)) slice_i (
      .clk(clk), .rst_n(rst_n),
      .cpu_hit(cpu_hit_oh[i]), .cpu_sel(cpu_sel), .cpu_data(cpu_data),
      .dma_hit(dma_hit_oh[i]), .dma_sel(dma_sel), .dma_data(dma_data),
      .req_set(req_set[i]), .cnt_dec(cnt_dec[i]),
      .en_q(chan_en[i]), .req_q(ch_req[i]), .mode_q(ch_mode[i]), .src_q(ch_src[i]),
      .dst_q(ch_dst[i]), .cnt_q(ch_cnt[i]), .viol_q(viol_flag[i]), .zero_evt(zero_evt[i]));
  end

  dma_irq_bank #(.NUM_CH(NUM_CH)) irq_i (
    .clk(clk), .rst_n(rst_n), .clr_hit(cpu_irq_hit), .clr_data(cpu_data),
    .hw_set(zero_evt), .pend_q(irq_pending));

  assign dma_self_err = |self_oh;
  assign rd_ch        = cpu_addr[RA_W-1:2];

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (int'(rd_ch) == i) begin
        unique case (reg_sel_e'(cpu_addr[1:0]))
          SEL_CTRL: begin
            rd_word[CTRL_EN_BIT]                 = chan_en[i];
            rd_word[CTRL_REQ_BIT]                = ch_req[i];
            rd_word[CTRL_MODE_LSB +: MODE_W]     = ch_mode[i];
          end
          SEL_SRC: rd_word[ADDR_W-1:0] = ch_src[i];
          SEL_DST: rd_word[ADDR_W-1:0] = ch_dst[i];
          SEL_CNT: rd_word[CNT_W-1:0]  = ch_cnt[i];
          default: rd_word = '0;
        endcase
      end
    end
    if (int'(rd_ch) == NUM_CH && cpu_addr[1:0] == 2'd0) rd_word[NUM_CH-1:0] = irq_pending;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_rdata  <= '0;
      cpu_rvalid <= 1'b0;
    end else begin
      cpu_rvalid <= cpu_rd_en;
      if (cpu_rd_en) cpu_rdata <= rd_word;
    end
  end
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int MODE_W = 4
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic [NUM_CH-1:0]                en,
  input logic [NUM_CH-1:0]                req,
  input logic [NUM_CH-1:0]                irq,
  input logic [NUM_CH-1:0]                viol,
  input logic [NUM_CH-1:0]                req_set,
  input logic [NUM_CH-1:0]                cnt_dec,
  input logic [NUM_CH-1:0]                cpu_hit,
  input logic [NUM_CH-1:0]                dma_hit,
  input logic [NUM_CH-1:0]                self_oh,
  input logic [NUM_CH-1:0][MODE_W-1:0]    mode,
  input logic [NUM_CH-1:0][ADDR_W-1:0]    src,
  input logic [NUM_CH-1:0][ADDR_W-1:0]    dst,
  input logic [NUM_CH-1:0][CNT_W-1:0]     cnt,
  input logic                             self_err
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_p
    AST_CNT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      $past(en[i]) && !$past(cnt_dec[i]) |-> $stable(cnt[i])); // R3
    AST_REQ_ONLY_HW_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req[i]) |-> $past(req_set[i])); // R4
    AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[i]) |-> (cnt[i] == '0) && ($past(cnt[i]) == CNT_W'(1))); // R6
    AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mode[i]) |-> !$past(en[i])); // R7
    AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(viol[i])); // R8
    AST_ADDR_BY_DMA_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(en[i]) && !$stable(src[i]) |-> $past(dma_hit[i])); // R9
    AST_SELF_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      self_oh[i] && !cpu_hit[i] |=> $stable(src[i]) && $stable(dst[i]) && $stable(cnt[i])); // R10
  end
  AST_SELF_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(self_oh) && (self_err == (self_oh != '0))); // R10
endmodule

bind dma_chan_regs dma_chan_regs_chk #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .MODE_W(MODE_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .en(chan_en), .req(ch_req), .irq(irq_pending),
  .viol(viol_flag), .req_set(req_set), .cnt_dec(cnt_dec), .cpu_hit(cpu_hit_oh),
  .dma_hit(dma_hit_oh), .self_oh(self_oh), .mode(ch_mode), .src(ch_src),
  .dst(ch_dst), .cnt(ch_cnt), .self_err(dma_self_err)
);

// File: tb/dma_chan_regs_tb_top.sv
`timescale 1ns/1ps
module dma_chan_regs_tb_top;
  localparam int NCH = 4;
  localparam int RAW = 5;
  localparam logic [1:0] S_CTRL = 2'd0, S_SRC = 2'd1, S_DST = 2'd2, S_CNT = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_wr_en = 0, cpu_rd_en = 0, dma_wr_en = 0;
  logic [RAW-1:0] cpu_addr = '0, dma_addr = '0;
  logic [31:0] cpu_wdata = '0, dma_wdata = '0, cpu_rdata;
  logic cpu_rvalid, dma_self_err;
  logic [1:0] dma_active_ch = '0;
  logic [NCH-1:0] req_set = '0, cnt_dec = '0, chan_en, irq_pending, viol_flag;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  typedef struct { logic [31:0] exp; string tag; } exp_t;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  dma_chan_regs dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_wr_en(cpu_wr_en), .cpu_rd_en(cpu_rd_en),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_rvalid(cpu_rvalid), .dma_wr_en(dma_wr_en), .dma_active_ch(dma_active_ch),
    .dma_addr(dma_addr), .dma_wdata(dma_wdata), .req_set(req_set), .cnt_dec(cnt_dec),
    .chan_en(chan_en), .irq_pending(irq_pending), .viol_flag(viol_flag),
    .dma_self_err(dma_self_err));

  function automatic logic [RAW-1:0] ra(input int ch, input logic [1:0] s);
    return RAW'((ch << 2) | s);
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (cpu_rvalid) begin
      if (sb_q.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL R2 unexpected read data: got %h expected none", cpu_rdata);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(e.tag, cpu_rdata, e.exp);
      end
    end
  end

  task automatic cpu_write(input logic [RAW-1:0] a, input logic [31:0] d);
    @(negedge clk); cpu_wr_en = 1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk); cpu_wr_en = 0;
    @(negedge clk);
  endtask

  task automatic cpu_read(input logic [RAW-1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); cpu_rd_en = 1; cpu_addr = a;
    sb_q.push_back('{exp, tag});
    @(negedge clk); cpu_rd_en = 0;
  endtask

  task automatic dma_write(input int act, input logic [RAW-1:0] a, input logic [31:0] d,
                           input logic exp_err, input string tag);
    @(negedge clk); dma_wr_en = 1; dma_active_ch = 2'(act); dma_addr = a; dma_wdata = d;
    @(negedge clk); dma_wr_en = 0;
    chk(tag, {31'd0, dma_self_err}, {31'd0, exp_err});
    @(negedge clk);
    chk({tag, " err single cycle"}, {31'd0, dma_self_err}, 32'd0);
  endtask

  task automatic dec_pulse(input int ch);
    @(negedge clk); cnt_dec[ch] = 1;
    @(negedge clk); cnt_dec[ch] = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 chan_en", 32'(chan_en), 0);
    chk("R1 irq_pending", 32'(irq_pending), 0);
    chk("R1 viol_flag", 32'(viol_flag), 0);
    chk("R1 self err", 32'(dma_self_err), 0);
    cpu_read(ra(0, S_CTRL), 0, "R1 ctrl0");
    cpu_read(ra(2, S_SRC), 0, "R1 src2");
    cpu_read(ra(3, S_CNT), 0, "R1 cnt3");

    // R2/R7 programming a disabled channel
    cpu_write(ra(1, S_SRC), 32'h1000_0040);
    cpu_write(ra(1, S_DST), 32'h2000_0080);
    cpu_write(ra(1, S_CNT), 32'd5);
    cpu_write(ra(1, S_CTRL), 32'h28);
    cpu_read(ra(1, S_SRC), 32'h1000_0040, "R2 src1");
    cpu_read(ra(1, S_DST), 32'h2000_0080, "R2 dst1");
    cpu_read(ra(1, S_CNT), 32'd5, "R2 cnt1");
    cpu_read(ra(1, S_CTRL), 32'h28, "R7 ctrl1 mode while disabled");

    // R7 enable with same mode, R8 no violation
    cpu_write(ra(1, S_CTRL), 32'h29);
    cpu_read(ra(1, S_CTRL), 32'h29, "R7 enable ch1");
    chk("R8 same mode no violation", 32'(viol_flag), 0);
    chk("R7 chan_en", 32'(chan_en), 32'h2);

    // R3 count locked
    cpu_write(ra(1, S_CNT), 32'h77);
    cpu_read(ra(1, S_CNT), 32'd5, "R3 count locked");
    chk("R3 no violation on count", 32'(viol_flag), 0);

    // R8 address write while enabled
    cpu_write(ra(1, S_SRC), 32'h0000_DEAD);
    cpu_read(ra(1, S_SRC), 32'h1000_0040, "R8 src kept");
    chk("R8 viol ch1", 32'(viol_flag), 32'h2);

    // R8 mode change while enabled
    cpu_write(ra(2, S_CTRL), 32'h0D);
    cpu_read(ra(2, S_CTRL), 32'h0D, "R7 ch2 mode+enable");
    cpu_write(ra(2, S_CTRL), 32'h15);
    cpu_read(ra(2, S_CTRL), 32'h0D, "R8 mode kept");
    chk("R8 viol ch2 sticky", 32'(viol_flag), 32'h6);

    // R4 request flag
    @(negedge clk); req_set[1] = 1;
    @(negedge clk); req_set[1] = 0;
    cpu_read(ra(1, S_CTRL), 32'h2B, "R4 set by strobe");
    cpu_write(ra(1, S_CTRL), 32'h2B);
    cpu_read(ra(1, S_CTRL), 32'h2B, "R4 write one no effect");
    @(negedge clk); cpu_wr_en = 1; cpu_addr = ra(1, S_CTRL); cpu_wdata = 32'h29;
    @(negedge clk); cpu_wr_en = 0; req_set[1] = 1;
    @(negedge clk); req_set[1] = 0;
    cpu_read(ra(1, S_CTRL), 32'h2B, "R4 set wins over clear");
    cpu_write(ra(1, S_CTRL), 32'h29);
    cpu_read(ra(1, S_CTRL), 32'h29, "R4 write zero clears");

    // R6 decrement to zero
    repeat (4) dec_pulse(1);
    cpu_read(ra(1, S_CNT), 32'd1, "R6 count after four");
    chk("R6 no irq before zero", 32'(irq_pending), 0);
    dec_pulse(1);
    chk("R6 irq at zero", 32'(irq_pending), 32'h2);
    dec_pulse(1);
    cpu_read(ra(1, S_CNT), 32'd0, "R6 zero holds");
    cpu_write(ra(0, S_CNT), 32'd3);
    dec_pulse(0);
    cpu_read(ra(0, S_CNT), 32'd3, "R6 disabled no decrement");

    // R5 selective clear
    cpu_write(ra(3, S_CNT), 32'd1);
    cpu_write(ra(3, S_CTRL), 32'h1);
    dec_pulse(3);
    chk("R6 irq ch3", 32'(irq_pending), 32'hA);
    cpu_write(ra(NCH, 2'd0), 32'hFFFF_FFF7);
    chk("R5 clear bit3 only", 32'(irq_pending), 32'h2);
    cpu_read(ra(NCH, 2'd0), 32'h2, "R5 read pending word");
    cpu_write(ra(0, S_CNT), 32'd1);
    cpu_write(ra(0, S_CTRL), 32'h1);
    @(negedge clk); cpu_wr_en = 1; cpu_addr = ra(NCH, 2'd0); cpu_wdata = 32'hFFFF_FFFE;
    @(negedge clk); cpu_wr_en = 0; cnt_dec[0] = 1;
    @(negedge clk); cnt_dec[0] = 0;
    chk("R6 set beats clear", 32'(irq_pending), 32'h3);
    cpu_write(ra(NCH, 2'd0), 32'h0);
    chk("R5 clear all", 32'(irq_pending), 0);

    // R9 cross-channel DMA write
    dma_write(0, ra(1, S_SRC), 32'h3000_0000, 1'b0, "R9 no self err");
    cpu_read(ra(1, S_SRC), 32'h3000_0000, "R9 src1 by dma");
    dma_write(0, ra(1, S_DST), 32'h3000_0100, 1'b0, "R9 no self err dst");
    cpu_read(ra(1, S_DST), 32'h3000_0100, "R9 dst1 by dma");
    chk("R9 viol unchanged", 32'(viol_flag), 32'h6);

    // R10 self-targeted DMA write
    dma_write(2, ra(2, S_DST), 32'h55, 1'b1, "R10 self err pulse");
    cpu_read(ra(2, S_DST), 32'h0, "R10 dst2 untouched");
    dma_write(3, ra(3, S_SRC), 32'h66, 1'b1, "R10 self err ch3");
    cpu_read(ra(3, S_SRC), 32'h0, "R10 src3 untouched");

    repeat (3) @(negedge clk);
    if (sb_q.size() != 0) begin
      n_tests++; n_fail++;
      $display("FAIL R2 missing read data: got %0d pending expected 0", sb_q.size());
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule